// File: doc/BRIEF.md
# Fetch Redirect and Squash Controller

This block chooses the address that a five-stage in-order pipeline fetches next. It also decides which young instructions become bubbles when control flow changes. The pipeline has no delay slots, so every instruction fetched down a path that is later abandoned must be squashed.

An unconditional PC-relative jump is acted on in decode, where its opcode and offset are known. It costs one bubble. A conditional branch and a register-indirect jump are acted on in execute, where the branch outcome or the register operand first exists. Each of these costs two bubbles.

An exception redirect from the commit point overrides both sources. The controller tracks which of its decode and execute slots hold squashed bubbles, so a bubble's stale jump flags can never steer fetch. Target adders and the condition comparator live elsewhere; only their results arrive here. All pins are plain control and address signals, with no valid/ready handshake, because the pipeline advances one stage every cycle.

Top module: `fetch_redirect`

## Requirements
- R1: While `rst_n` is low, and at the first cycle after release, `fetch_pc` equals the parameter `RESET_PC` (default 0x0000_1000), and all three kill outputs are low. Immediately after reset the decode and execute slots count as bubbles.
- R2: With no redirect, `next_pc` equals `fetch_pc + 4` and all kill outputs are low.
- R3: A decode jump (`dec_jump`=1) in a live decode slot, with no execute redirect and no exception, sets `next_pc` to `dec_target` and raises `kill_fetch` only.
- R4: A conditional branch in a live execute slot (`exe_branch`=1) whose outcome is taken (`exe_taken`=1) sets `next_pc` to `exe_target` and raises `kill_fetch` and `kill_decode`, with `kill_execute` low.
- R5: A conditional branch with `exe_taken`=0 causes no redirect: `next_pc` is `fetch_pc + 4` and every kill output is low.
- R6: A register-indirect jump in a live execute slot (`exe_jumpreg`=1) redirects to `exe_target` regardless of `exe_taken`, and raises `kill_fetch` and `kill_decode`.
- R7: When an execute redirect and a decode jump are presented together, the execute redirect wins: `next_pc` is `exe_target`.
- R8: `exc_valid`=1 overrides both branch sources. `next_pc` becomes `exc_vector` and all three kill outputs are high, even while both the decode and execute slots are bubbles.
- R9: Jump flags that belong to a squashed instruction are ignored. After any kill of fetch, the decode slot of the following cycle is a bubble. After a kill of decode, the execute slot of the following cycle is a bubble. `dec_jump` is ignored while the decode slot is a bubble. `exe_branch` and `exe_jumpreg` are ignored while the execute slot is a bubble. In both cases `next_pc` stays `fetch_pc + 4` and no kill output rises.
- R10: On every clock edge out of reset, `fetch_pc` takes the value `next_pc` had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_jump | input | 1 | Decode slot holds an unconditional PC-relative jump |
| dec_target | input | 32 | Jump target computed in decode |
| exe_branch | input | 1 | Execute slot holds a conditional branch |
| exe_jumpreg | input | 1 | Execute slot holds a register-indirect jump |
| exe_taken | input | 1 | Branch condition result from the comparator |
| exe_target | input | 32 | Target computed in execute |
| exc_valid | input | 1 | Exception redirect from the commit point |
| exc_vector | input | 32 | Handler address |
| fetch_pc | output | 32 | Address being fetched this cycle |
| next_pc | output | 32 | Address to fetch in the next cycle |
| kill_fetch | output | 1 | Squash the instruction in fetch |
| kill_decode | output | 1 | Squash the instruction in decode |
| kill_execute | output | 1 | Squash the instruction in execute |

## Verification
The bench feeds jump flags into slots that a previous redirect has just emptied. A design without slot tracking would jump a second time, to a bogus target, and raise kills it should not. It presents execute and decode redirects together, and exceptions on top of both. A wrong priority shows up as the younger target on `next_pc`. A wrong mask shows up as a missing `kill_decode` or `kill_execute`. Not-taken branches and register jumps with `exe_taken` low tell apart a design that checks the condition for the wrong kind of instruction. A mid-run reset checks that the slots come back as bubbles.

// File: rtl/fetch_redirect_pkg.sv
package fetch_redirect_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_DEC = 2'd1,
    SRC_EXE = 2'd2,
    SRC_EXC = 2'd3
  } redir_src_e;

  localparam int unsigned KILL_W = 3;
  localparam int unsigned K_FETCH = 0;
  localparam int unsigned K_DECODE = 1;
  localparam int unsigned K_EXECUTE = 2;

endpackage

// File: rtl/slot_tracker.sv
module slot_tracker
  import fetch_redirect_pkg::*;
#(
  parameter int unsigned TRACKED = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KILL_W-1:0] kill,
  output logic [TRACKED:1]  live
);

  logic [TRACKED:0] chain;

  assign chain[0] = 1'b1;

  for (genvar s = 1; s <= TRACKED; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= 1'b0;
      else        chain[s] <= chain[s-1] & ~kill[s-1];
    end
  end

  assign live = chain[TRACKED:1];

  // R9: a slot that was squashed comes back as a bubble next cycle
  p_bubble_after_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kill[K_FETCH] |=> !live[1]);

endmodule

// File: rtl/redirect_arb.sv
module redirect_arb
  import fetch_redirect_pkg::*;
(
  input  logic              d_live,
  input  logic              x_live,
  input  logic              dec_jump,
  input  logic              exe_branch,
  input  logic              exe_jumpreg,
  input  logic              exe_taken,
  input  logic              exc_valid,
  output redir_src_e        src,
  output logic [KILL_W-1:0] kill
);

  logic dec_req;
  logic exe_req;

  assign dec_req = d_live & dec_jump;
  assign exe_req = x_live & (exe_jumpreg | (exe_branch & exe_taken));

  always_comb begin
    src  = SRC_SEQ;
    kill = '0;
    if (exc_valid) begin
      src  = SRC_EXC;
      kill = '1;
    end else if (exe_req) begin
      src               = SRC_EXE;
      kill[K_FETCH]     = 1'b1;
      kill[K_DECODE]    = 1'b1;
    end else if (dec_req) begin
      src           = SRC_DEC;
      kill[K_FETCH] = 1'b1;
    end
  end

  always_comb begin
    // R4: a deeper kill always implies every shallower kill
    p_kill_nested_r4: assert (!(kill[K_DECODE] && !kill[K_FETCH]));
  end

endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import fetch_redirect_pkg::*;
#(
  parameter int unsigned          XLEN     = 32,
  parameter int unsigned          STEP     = 4,
  parameter logic [XLEN-1:0]      RESET_PC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  redir_src_e      src,
  input  logic [XLEN-1:0] dec_target,
  input  logic [XLEN-1:0] exe_target,
  input  logic [XLEN-1:0] exc_vector,
  output logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] next_pc
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] seq_pc;

  assign seq_pc = fetch_pc + STEP_V;

  always_comb begin
    unique case (src)
      SRC_DEC: next_pc = dec_target;
      SRC_EXE: next_pc = exe_target;
      SRC_EXC: next_pc = exc_vector;
      default: next_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fetch_pc <= RESET_PC;
    else        fetch_pc <= next_pc;
  end

  // R10: the fetch address follows the previous cycle's choice
  p_pc_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> fetch_pc == $past(next_pc));

endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fetch_redirect_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_jump,
  input  logic [XLEN-1:0] dec_target,
  input  logic            exe_branch,
  input  logic            exe_jumpreg,
  input  logic            exe_taken,
  input  logic [XLEN-1:0] exe_target,
  input  logic            exc_valid,
  input  logic [XLEN-1:0] exc_vector,
  output logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] next_pc,
  output logic            kill_fetch,
  output logic            kill_decode,
  output logic            kill_execute
);

  localparam int unsigned TRACKED = KILL_W - 1;

  redir_src_e        src;
  logic [KILL_W-1:0] kill;
  logic [TRACKED:1]  live;

  slot_tracker #(.TRACKED(TRACKED)) u_track (
    .clk  (clk),
    .rst_n(rst_n),
    .kill (kill),
    .live (live)
  );

  redirect_arb u_arb (
    .d_live     (live[1]),
    .x_live     (live[2]),
    .dec_jump   (dec_jump),
    .exe_branch (exe_branch),
    .exe_jumpreg(exe_jumpreg),
    .exe_taken  (exe_taken),
    .exc_valid  (exc_valid),
    .src        (src),
    .kill       (kill)
  );

  pc_seq #(.XLEN(XLEN), .STEP(STEP), .RESET_PC(RESET_PC)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .dec_target(dec_target),
    .exe_target(exe_target),
    .exc_vector(exc_vector),
    .fetch_pc  (fetch_pc),
    .next_pc   (next_pc)
  );

  assign kill_fetch   = kill[K_FETCH];
  assign kill_decode  = kill[K_DECODE];
  assign kill_execute = kill[K_EXECUTE];

  // R2: without any kill the fetch stream is sequential
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_fetch |-> next_pc == fetch_pc + XLEN'(STEP));

  // R8: an exception squashes every younger stage and vectors fetch
  p_exc_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> kill_fetch && kill_decode && kill_execute && next_pc == exc_vector);

  // R9: two bubbles behind an execute redirect leave nothing to redirect
  p_dead_slots_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid && !live[1] && !live[2] |-> !kill_fetch);

  // R7: execute-stage redirect beats a simultaneous decode jump
  p_exe_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_decode && !exc_valid |-> next_pc == exe_target);

endmodule

// File: tb/tb_fetch_redirect.sv
module tb_fetch_redirect;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_jump, exe_branch, exe_jumpreg, exe_taken, exc_valid;
  logic [31:0] dec_target, exe_target, exc_vector;
  logic [31:0] fetch_pc, next_pc;
  logic        kill_fetch, kill_decode, kill_execute;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fetch_redirect dut (
    .clk(clk), .rst_n(rst_n),
    .dec_jump(dec_jump), .dec_target(dec_target),
    .exe_branch(exe_branch), .exe_jumpreg(exe_jumpreg),
    .exe_taken(exe_taken), .exe_target(exe_target),
    .exc_valid(exc_valid), .exc_vector(exc_vector),
    .fetch_pc(fetch_pc), .next_pc(next_pc),
    .kill_fetch(kill_fetch), .kill_decode(kill_decode), .kill_execute(kill_execute)
  );

  typedef struct packed {
    logic        dj;
    logic [31:0] dt;
    logic        eb;
    logic        ej;
    logic        ec;
    logic [31:0] et;
    logic        ex;
    logic [31:0] ev;
    logic [31:0] np;
    logic        kf;
    logic        kd;
    logic        kx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    // R1 / R9: right after reset both slots are bubbles, flags ignored
    '{1'b1, 32'h0000_7777, 1'b1, 1'b0, 1'b1, 32'h0000_6666, 1'b0, 32'h0, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 8'd1},
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_6666, 1'b0, 32'h0, 32'h0000_1008, 1'b0, 1'b0, 1'b0, 8'd9},
    // R2: plain sequential
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_100C, 1'b0, 1'b0, 1'b0, 8'd2},
    // R5: branch not taken
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0000_5555, 1'b0, 32'h0, 32'h0000_1010, 1'b0, 1'b0, 1'b0, 8'd5},
    // R3: decode jump
    '{1'b1, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 8'd3},
    // R9: decode bubble's jump ignored
    '{1'b1, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_2004, 1'b0, 1'b0, 1'b0, 8'd9},
    // R9: execute bubble's taken branch ignored
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_5000, 1'b0, 32'h0, 32'h0000_2008, 1'b0, 1'b0, 1'b0, 8'd9},
    // R4: taken branch
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_4000, 1'b0, 32'h0, 32'h0000_4000, 1'b1, 1'b1, 1'b0, 8'd4},
    // R9: both slots bubbles after execute redirect
    '{1'b1, 32'h0000_7000, 1'b0, 1'b1, 1'b0, 32'h0000_6000, 1'b0, 32'h0, 32'h0000_4004, 1'b0, 1'b0, 1'b0, 8'd9},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_4008, 1'b0, 1'b0, 1'b0, 8'd2},
    // R6: register jump, condition low
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_8000, 1'b0, 32'h0, 32'h0000_8000, 1'b1, 1'b1, 1'b0, 8'd6},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_8004, 1'b0, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_8008, 1'b0, 1'b0, 1'b0, 8'd2},
    // R7: execute beats decode
    '{1'b1, 32'h0000_9000, 1'b1, 1'b0, 1'b1, 32'h0000_A000, 1'b0, 32'h0, 32'h0000_A000, 1'b1, 1'b1, 1'b0, 8'd7},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_A004, 1'b0, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_A008, 1'b0, 1'b0, 1'b0, 8'd2},
    // R8: exception over both sources
    '{1'b1, 32'h0000_9000, 1'b0, 1'b1, 1'b0, 32'h0000_B000, 1'b1, 32'h100, 32'h0000_0100, 1'b1, 1'b1, 1'b1, 8'd8},
    '{1'b1, 32'h0000_9000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_0104, 1'b0, 1'b0, 1'b0, 8'd9},
    // R8: exception while execute slot is a bubble
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 32'h200, 32'h0000_0200, 1'b1, 1'b1, 1'b1, 8'd8},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_0204, 1'b0, 1'b0, 1'b0, 8'd2},
    // R3: decode jump, jump itself moves on to execute
    '{1'b1, 32'h0000_0300, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_0300, 1'b1, 1'b0, 1'b0, 8'd3},
    // R6: register jump from live execute behind a decode bubble
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_0400, 1'b0, 32'h0, 32'h0000_0400, 1'b1, 1'b1, 1'b0, 8'd6},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0, 32'h0000_0404, 1'b0, 1'b0, 1'b0, 8'd2}
  };

  task automatic check32(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dec_jump = 0; dec_target = 0; exe_branch = 0; exe_jumpreg = 0;
    exe_taken = 0; exe_target = 0; exc_valid = 0; exc_vector = 0;
  endtask

  initial begin : watchdog
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] exp_pc;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    check32("fetch_pc in reset", 1, fetch_pc, 32'h0000_1000);
    rst_n = 1;
    exp_pc = 32'h0000_1000;
    for (int i = 0; i < NV; i++) begin
      dec_jump = VEC[i].dj; dec_target = VEC[i].dt;
      exe_branch = VEC[i].eb; exe_jumpreg = VEC[i].ej;
      exe_taken = VEC[i].ec; exe_target = VEC[i].et;
      exc_valid = VEC[i].ex; exc_vector = VEC[i].ev;
      #5;
      // R10: fetch_pc tracks previous next_pc
      check32("fetch_pc", 10, fetch_pc, exp_pc);
      check32("next_pc", int'(VEC[i].req), next_pc, VEC[i].np);
      check32("kills", int'(VEC[i].req), {29'd0, kill_execute, kill_decode, kill_fetch},
              {29'd0, VEC[i].kx, VEC[i].kd, VEC[i].kf});
      exp_pc = VEC[i].np;
      @(negedge clk);
    end

    // R1: mid-run reset restores start address and bubble slots
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    dec_jump = 1; dec_target = 32'h0000_E000;
    exe_jumpreg = 1; exe_target = 32'h0000_F000;
    #5;
    check32("fetch_pc after reset", 1, fetch_pc, 32'h0000_1000);
    check32("next_pc after reset", 1, next_pc, 32'h0000_1004);
    check32("kills after reset", 1, {29'd0, kill_execute, kill_decode, kill_fetch}, 32'd0);
    @(negedge clk);
    idle_inputs();
    #5;
    check32("fetch_pc step", 10, fetch_pc, 32'h0000_1004);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule